// File: doc/BRIEF.md
# Region-Split Two-Level Virtual Address Translator

The block turns a 32-bit virtual address into a 30-bit physical address. The two most significant address bits pick one of four regions: a user program area, a user stack area, a system area shared by every process, or a code that is not allowed. The system area is mapped by one table in physical memory, located by a base register and limited by a length register. The tables for the two user areas are not in physical memory. They sit in system virtual space, so a user translation first works out the system virtual address of the entry it needs. It then translates that address through the system table, and only after that reads the user entry itself.

A requester raises `start` for one cycle with an address, a 2-bit privilege mode and a write flag. The block reads table entries through a simple read port that has one read outstanding at a time. It checks validity and the access limits of the final entry, writes that entry back with its modified bit set when the access is a write, and finally pulses `done` with a status code and the physical address. Range faults are found before any memory access. The stack area's length check counts from the top of the space downward.

Top module: `vspace_walker`

## Requirements
- R1: Address bits 31:30 select the region: 00 program, 01 stack, 10 system, 11 not allowed. Code 11 finishes with status 1 and makes no memory access.
- R2: For a system address, the entry is read from physical address sys_base + 4 × vpn, where vpn is bits 29:9. A vpn at or above sys_len finishes with status 2 and makes no memory access.
- R3: For a program address, the entry lives at system virtual address tv = prg_base + 4 × vpn. The first read is at sys_base + 4 × tv[29:9]. The second read is at {pfn of that first entry, tv[8:0]}. A vpn at or above prg_len gives status 2 with no access.
- R4: A stack address is translated like R3 but uses stk_base, and its vpn is accepted only when it is at or above stk_len. A vpn below stk_len gives status 2 with no memory access.
- R5: A user entry address tv whose bits 31:30 are not 10 gives status 6. A tv whose page tv[29:9] is at or above sys_len gives status 2. Neither case makes a memory access.
- R6: An entry holds valid at bit 31, a 4-bit limit field at bits 30:27, modified at bit 26 and the frame number at bits 20:0. A successful lookup returns status 0 and paddr = {frame, vaddr[8:0]}.
- R7: A clear valid bit in the system entry fetched for a user table gives status 3. A clear valid bit in the final entry gives status 4.
- R8: The write limit is entry bits 30:29 and the read limit is bits 28:27. An access whose mode is above the limit for its access type gives status 5 and writes nothing.
- R9: An allowed write stores the final entry, with bit 26 set, back to the address it was read from. This happens once, before `done`.
- R10: At most one read is outstanding. A `start` while a walk is in progress is ignored. `done` is a one-cycle pulse, and a `start` in the same cycle as `done` is accepted.
- R11: After reset, `done`, `mem_rd_req` and `mem_wr_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a translation (one-cycle pulse) |
| vaddr | input | 32 | Virtual address to translate |
| mode | input | 2 | Privilege mode of the access, 0 is most privileged |
| write | input | 1 | Access is a write |
| sys_base | input | 30 | Physical address of the system table |
| sys_len | input | 22 | Entry count of the system table |
| prg_base | input | 32 | System virtual address of the program table |
| prg_len | input | 22 | Entry count of the program table |
| stk_base | input | 32 | System virtual address of the stack table |
| stk_len | input | 22 | Lowest valid stack page number |
| mem_rd_req | output | 1 | Read request, one cycle |
| mem_wr_req | output | 1 | Write request, one cycle |
| mem_addr | output | 30 | Physical address of the request |
| mem_wdata | output | 32 | Entry written back |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | Result valid pulse |
| status | output | 3 | 0 ok, 1 bad region, 2 length, 3 table-page fault, 4 leaf fault, 5 access, 6 table outside system space |
| paddr | output | 30 | Translated physical address |

## Verification
Completion of one walk and acceptance of the next request can fall in the same cycle. The block is idle in the cycle where `done` is high, so a new `start` there must be taken up. The bench raises `start` for a request in the not-allowed region exactly on the cycle it first sees `done`. It expects the previous walk's result in that cycle and a second `done`, carrying status 1, in the next one. It also pulses `start` in the middle of a two-read walk and checks that the walk still makes exactly two reads and returns its own address.

// File: rtl/vx_pkg.sv
package vx_pkg;

    localparam int PTE_W      = 32;
    localparam int PTE_V_BIT  = 31;
    localparam int PTE_WL_HI  = 30;
    localparam int PTE_RL_HI  = 28;
    localparam int PTE_M_BIT  = 26;

    typedef enum logic [1:0] {
        RG_PROG  = 2'b00,
        RG_STACK = 2'b01,
        RG_SYS   = 2'b10,
        RG_BAD   = 2'b11
    } vx_region_e;

    typedef enum logic [2:0] {
        ST_OK      = 3'd0,
        ST_BAD_RGN = 3'd1,
        ST_LEN     = 3'd2,
        ST_PF_TBL  = 3'd3,
        ST_PF_LEAF = 3'd4,
        ST_ACCV    = 3'd5,
        ST_TBL_RGN = 3'd6
    } vx_status_e;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_RD_ISSUE = 2'd1,
        S_RD_WAIT  = 2'd2,
        S_WB       = 2'd3
    } walk_st_e;

endpackage

// File: rtl/vx_region_decode.sv
module vx_region_decode
    import vx_pkg::*;
#(
    parameter int OFS_W = 9,
    parameter int VPN_W = 21,
    parameter int PA_W  = 30,
    parameter int VA_W  = 2 + VPN_W + OFS_W,
    parameter int LEN_W = VPN_W + 1
) (
    input  logic [VA_W-1:0]  vaddr,
    input  logic [PA_W-1:0]  sys_base,
    input  logic [LEN_W-1:0] sys_len,
    input  logic [VA_W-1:0]  prg_base,
    input  logic [LEN_W-1:0] prg_len,
    input  logic [VA_W-1:0]  stk_base,
    input  logic [LEN_W-1:0] stk_len,
    output logic             fault,
    output vx_status_e       fault_code,
    output logic             nested,
    output logic [PA_W-1:0]  first_addr,
    output logic [OFS_W-1:0] tbl_ofs
);
    localparam int SHW = VPN_W + 2;

    logic [1:0]       rgn;
    logic [VPN_W-1:0] vpn;
    logic [LEN_W-1:0] vpn_x;
    logic [SHW-1:0]   vpn_b;
    logic [PA_W-1:0]  sys_ent;
    logic [VA_W-1:0]  usr_base;
    logic             usr_in_range;
    logic [VA_W-1:0]  tbl_va;
    logic [VPN_W-1:0] tbl_vpn;
    logic [1:0]       tbl_rgn;
    logic [PA_W-1:0]  tbl_ent;

    assign rgn     = vaddr[VA_W-1 -: 2];
    assign vpn     = vaddr[OFS_W +: VPN_W];
    assign vpn_x   = {1'b0, vpn};
    assign vpn_b   = {vpn, 2'b00};
    assign sys_ent = sys_base + PA_W'(vpn_b);

    // stack pages count downward from the top: valid at or above the limit
    assign usr_base     = (rgn == RG_STACK) ? stk_base : prg_base;
    assign usr_in_range = (rgn == RG_STACK) ? (vpn_x >= stk_len) : (vpn_x < prg_len);

    // system virtual address of the user entry, then its system table slot
    assign tbl_va  = usr_base + VA_W'(vpn_b);
    assign tbl_vpn = tbl_va[OFS_W +: VPN_W];
    assign tbl_rgn = tbl_va[VA_W-1 -: 2];
    assign tbl_ent = sys_base + PA_W'({tbl_vpn, 2'b00});
    assign tbl_ofs = tbl_va[OFS_W-1:0];

    always_comb begin
        fault      = 1'b0;
        fault_code = ST_OK;
        nested     = 1'b0;
        first_addr = sys_ent;
        case (vx_region_e'(rgn))
            RG_BAD: begin
                fault      = 1'b1;
                fault_code = ST_BAD_RGN;
            end
            RG_SYS: begin
                if (vpn_x >= sys_len) begin
                    fault      = 1'b1;
                    fault_code = ST_LEN;
                end
            end
            default: begin
                if (!usr_in_range) begin
                    fault      = 1'b1;
                    fault_code = ST_LEN;
                end else if (tbl_rgn != RG_SYS) begin
                    fault      = 1'b1;
                    fault_code = ST_TBL_RGN;
                end else if ({1'b0, tbl_vpn} >= sys_len) begin
                    fault      = 1'b1;
                    fault_code = ST_LEN;
                end else begin
                    nested     = 1'b1;
                    first_addr = tbl_ent;
                end
            end
        endcase
    end

endmodule

// File: rtl/vx_pte_eval.sv
module vx_pte_eval
    import vx_pkg::*;
#(
    parameter int PFN_W = 21
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [1:0]       mode,
    input  logic             write,
    output logic             valid,
    output logic             allowed,
    output logic [PFN_W-1:0] pfn,
    output logic [PTE_W-1:0] pte_dirty
);
    logic [1:0] limit;

    assign valid     = pte[PTE_V_BIT];
    assign limit     = write ? pte[PTE_WL_HI -: 2] : pte[PTE_RL_HI -: 2];
    assign allowed   = (mode <= limit);
    assign pfn       = pte[PFN_W-1:0];
    assign pte_dirty = pte | (PTE_W'(1) << PTE_M_BIT);

endmodule

// File: rtl/vspace_walker.sv
module vspace_walker
    import vx_pkg::*;
#(
    parameter int OFS_W = 9,
    parameter int VPN_W = 21,
    parameter int PFN_W = 21,
    localparam int VA_W  = 2 + VPN_W + OFS_W,
    localparam int PA_W  = PFN_W + OFS_W,
    localparam int LEN_W = VPN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [1:0]       mode,
    input  logic             write,
    input  logic [PA_W-1:0]  sys_base,
    input  logic [LEN_W-1:0] sys_len,
    input  logic [VA_W-1:0]  prg_base,
    input  logic [LEN_W-1:0] prg_len,
    input  logic [VA_W-1:0]  stk_base,
    input  logic [LEN_W-1:0] stk_len,
    output logic             mem_rd_req,
    output logic             mem_wr_req,
    output logic [PA_W-1:0]  mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_rvalid,
    input  logic [31:0]      mem_rdata,
    output logic             done,
    output logic [2:0]       status,
    output logic [PA_W-1:0]  paddr
);
    typedef struct packed {
        walk_st_e         st;
        logic             leaf;
        logic [OFS_W-1:0] va_ofs;
        logic [OFS_W-1:0] tbl_ofs;
        logic [1:0]       mode;
        logic             wr;
        logic [PA_W-1:0]  addr;
        logic [PTE_W-1:0] wdata;
        logic             done;
        vx_status_e       status;
        logic [PA_W-1:0]  paddr;
    } walk_t;

    walk_t walk_d, walk_q;

    logic             dec_fault;
    vx_status_e       dec_code;
    logic             dec_nested;
    logic [PA_W-1:0]  dec_addr;
    logic [OFS_W-1:0] dec_tbl_ofs;

    logic             pe_valid;
    logic             pe_allowed;
    logic [PFN_W-1:0] pe_pfn;
    logic [PTE_W-1:0] pe_dirty;

    vx_region_decode #(
        .OFS_W (OFS_W),
        .VPN_W (VPN_W),
        .PA_W  (PA_W)
    ) i_decode (
        .vaddr      (vaddr),
        .sys_base   (sys_base),
        .sys_len    (sys_len),
        .prg_base   (prg_base),
        .prg_len    (prg_len),
        .stk_base   (stk_base),
        .stk_len    (stk_len),
        .fault      (dec_fault),
        .fault_code (dec_code),
        .nested     (dec_nested),
        .first_addr (dec_addr),
        .tbl_ofs    (dec_tbl_ofs)
    );

    vx_pte_eval #(
        .PFN_W (PFN_W)
    ) i_pte_eval (
        .pte       (mem_rdata),
        .mode      (walk_q.mode),
        .write     (walk_q.wr),
        .valid     (pe_valid),
        .allowed   (pe_allowed),
        .pfn       (pe_pfn),
        .pte_dirty (pe_dirty)
    );

    always_comb begin
        walk_d      = walk_q;
        walk_d.done = 1'b0;
        case (walk_q.st)
            S_IDLE: begin
                if (start) begin
                    walk_d.va_ofs  = vaddr[OFS_W-1:0];
                    walk_d.tbl_ofs = dec_tbl_ofs;
                    walk_d.mode    = mode;
                    walk_d.wr      = write;
                    if (dec_fault) begin
                        walk_d.done   = 1'b1;
                        walk_d.status = dec_code;
                        walk_d.paddr  = '0;
                    end else begin
                        walk_d.addr = dec_addr;
                        walk_d.leaf = !dec_nested;
                        walk_d.st   = S_RD_ISSUE;
                    end
                end
            end
            S_RD_ISSUE: begin
                walk_d.st = S_RD_WAIT;
            end
            S_RD_WAIT: begin
                if (mem_rvalid) begin
                    if (!walk_q.leaf) begin
                        if (!pe_valid) begin
                            walk_d.done   = 1'b1;
                            walk_d.status = ST_PF_TBL;
                            walk_d.paddr  = '0;
                            walk_d.st     = S_IDLE;
                        end else begin
                            walk_d.addr = {pe_pfn, walk_q.tbl_ofs};
                            walk_d.leaf = 1'b1;
                            walk_d.st   = S_RD_ISSUE;
                        end
                    end else if (!pe_valid) begin
                        walk_d.done   = 1'b1;
                        walk_d.status = ST_PF_LEAF;
                        walk_d.paddr  = '0;
                        walk_d.st     = S_IDLE;
                    end else if (!pe_allowed) begin
                        walk_d.done   = 1'b1;
                        walk_d.status = ST_ACCV;
                        walk_d.paddr  = '0;
                        walk_d.st     = S_IDLE;
                    end else begin
                        walk_d.paddr  = {pe_pfn, walk_q.va_ofs};
                        walk_d.status = ST_OK;
                        if (walk_q.wr) begin
                            walk_d.wdata = pe_dirty;
                            walk_d.st    = S_WB;
                        end else begin
                            walk_d.done = 1'b1;
                            walk_d.st   = S_IDLE;
                        end
                    end
                end
            end
            S_WB: begin
                walk_d.done = 1'b1;
                walk_d.st   = S_IDLE;
            end
            default: walk_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_q <= '0;
        end else begin
            walk_q <= walk_d;
        end
    end

    assign mem_rd_req = (walk_q.st == S_RD_ISSUE);
    assign mem_wr_req = (walk_q.st == S_WB);
    assign mem_addr   = walk_q.addr;
    assign mem_wdata  = walk_q.wdata;
    assign done       = walk_q.done;
    assign status     = walk_q.status;
    assign paddr      = walk_q.paddr;

endmodule

// File: rtl/vx_walk_chk.sv
module vx_walk_chk
    import vx_pkg::*;
#(
    parameter int OFS_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [1:0]       va_rgn,
    input logic [OFS_W-1:0] va_ofs,
    input logic             write,
    input logic             mem_rd_req,
    input logic             mem_wr_req,
    input logic             wb_mbit,
    input logic             done,
    input logic [2:0]       status,
    input logic [OFS_W-1:0] pa_ofs
);
    logic             busy_c;
    logic             take;
    logic [1:0]       sv_rgn;
    logic [OFS_W-1:0] sv_ofs;
    logic             sv_wr;

    assign take = start && (!busy_c || done);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_c <= 1'b0;
            sv_rgn <= '0;
            sv_ofs <= '0;
            sv_wr  <= 1'b0;
        end else begin
            busy_c <= done ? start : (busy_c || start);
            if (take) begin
                sv_rgn <= va_rgn;
                sv_ofs <= va_ofs;
                sv_wr  <= write;
            end
        end
    end

    p_bad_region_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sv_rgn == RG_BAD) |-> (status == ST_BAD_RGN))
        else $error("bad region did not report its status");

    p_offset_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == ST_OK) |-> (pa_ofs == sv_ofs))
        else $error("page offset not carried into the physical address");

    p_wb_marks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> (sv_wr && wb_mbit))
        else $error("write-back without a write access or without modified bit");

    p_single_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req)
        else $error("back-to-back read requests");

    p_quiet_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_c |-> (!mem_rd_req && !mem_wr_req))
        else $error("memory access with no walk in progress");

    p_done_in_walk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy_c)
        else $error("done without an accepted request");

    p_no_mix_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req))
        else $error("read and write requested together");

endmodule

bind vspace_walker vx_walk_chk #(
    .OFS_W (OFS_W)
) i_walk_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .va_rgn     (vaddr[VA_W-1 -: 2]),
    .va_ofs     (vaddr[OFS_W-1:0]),
    .write      (write),
    .mem_rd_req (mem_rd_req),
    .mem_wr_req (mem_wr_req),
    .wb_mbit    (mem_wdata[26]),
    .done       (done),
    .status     (status),
    .pa_ofs     (paddr[OFS_W-1:0])
);

// File: tb/test_vspace_walker.sv
module test_vspace_walker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [31:0] vaddr;
    logic [1:0]  mode;
    logic        write;
    logic [29:0] sys_base;
    logic [21:0] sys_len;
    logic [31:0] prg_base;
    logic [21:0] prg_len;
    logic [31:0] stk_base;
    logic [21:0] stk_len;
    logic        mem_rd_req;
    logic        mem_wr_req;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        done;
    logic [2:0]  status;
    logic [29:0] paddr;

    always #4 clk = ~clk;

    vspace_walker i_vspace_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .vaddr      (vaddr),
        .mode       (mode),
        .write      (write),
        .sys_base   (sys_base),
        .sys_len    (sys_len),
        .prg_base   (prg_base),
        .prg_len    (prg_len),
        .stk_base   (stk_base),
        .stk_len    (stk_len),
        .mem_rd_req (mem_rd_req),
        .mem_wr_req (mem_wr_req),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .done       (done),
        .status     (status),
        .paddr      (paddr)
    );

    // memory model: 512 words, read latency of three cycles, writes logged
    logic [31:0] mem [0:511];
    logic [2:0]  rv_pipe = '0;
    logic [29:0] ap0 = '0, ap1 = '0, ap2 = '0;
    logic [29:0] rd_log [0:63];
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [29:0] wr_addr_last = '0;
    logic [31:0] wr_data_last = '0;

    always @(posedge clk) begin
        rv_pipe <= {rv_pipe[1:0], mem_rd_req};
        ap0     <= mem_addr;
        ap1     <= ap0;
        ap2     <= ap1;
        if (mem_rd_req) begin
            rd_log[rd_cnt % 64] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
        if (mem_wr_req) begin
            wr_addr_last <= mem_addr;
            wr_data_last <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end
    assign mem_rvalid = rv_pipe[2];
    assign mem_rdata  = mem[ap2[10:2]];

    int n_chk  = 0;
    int n_fail = 0;
    int rd_base, wr_base;
    logic [2:0]  r_st;
    logic [29:0] r_pa;
    int          r_nrd, r_nwr;

    function automatic logic [31:0] mk_pte(input logic v, input logic [3:0] lim,
                                           input logic m, input logic [20:0] pfn);
        return {v, lim, m, 5'b0, pfn};
    endfunction

    function automatic logic [31:0] mk_va(input logic [1:0] rg, input logic [20:0] vpn,
                                          input logic [8:0] ofs);
        return {rg, vpn, ofs};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] va, input logic [1:0] md, input logic wr);
        @(negedge clk);
        vaddr   = va;
        mode    = md;
        write   = wr;
        start   = 1'b1;
        rd_base = rd_cnt;
        wr_base = wr_cnt;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL R10: done never arrived");
        end
        r_st  = status;
        r_pa  = paddr;
        r_nrd = rd_cnt - rd_base;
        r_nwr = wr_cnt - wr_base;
    endtask

    task automatic run(input logic [31:0] va, input logic [1:0] md, input logic wr);
        issue(va, md, wr);
        wait_done();
    endtask

    task automatic t_reset();
        chk("R11 done low", 64'(done), 0);
        chk("R11 no read", 64'(mem_rd_req), 0);
        chk("R11 no write", 64'(mem_wr_req), 0);
    endtask

    task automatic t_system();
        run(mk_va(2'b10, 21'd5, 9'h1AB), 2'd3, 1'b0);
        chk("R2 status", 64'(r_st), 0);
        chk("R6 paddr", 64'(r_pa), 64'({21'h12345, 9'h1AB}));
        chk("R2 read count", 64'(r_nrd), 1);
        chk("R2 entry address", 64'(rd_log[rd_base % 64]), 64'h114);
        run(mk_va(2'b10, 21'd8, 9'h0), 2'd0, 1'b0);
        chk("R2 length fault", 64'(r_st), 2);
        chk("R2 no access", 64'(r_nrd), 0);
        run(mk_va(2'b10, 21'd7, 9'h0), 2'd0, 1'b0);
        chk("R2 last entry ok", 64'(r_pa), 64'({21'h00ABC, 9'h0}));
    endtask

    task automatic t_bad_region();
        run(mk_va(2'b11, 21'd1, 9'h5), 2'd0, 1'b0);
        chk("R1 status", 64'(r_st), 1);
        chk("R1 no access", 64'(r_nrd), 0);
    endtask

    task automatic t_program();
        run(mk_va(2'b00, 21'd0, 9'h055), 2'd2, 1'b0);
        chk("R3 status", 64'(r_st), 0);
        chk("R3 reads", 64'(r_nrd), 2);
        chk("R3 first read", 64'(rd_log[rd_base % 64]), 64'h108);
        chk("R3 second read", 64'(rd_log[(rd_base + 1) % 64]), 64'h210);
        chk("R3 paddr", 64'(r_pa), 64'({21'h00077, 9'h055}));
        run(mk_va(2'b00, 21'd4, 9'h0), 2'd0, 1'b0);
        chk("R3 length fault", 64'(r_st), 2);
        chk("R3 no access", 64'(r_nrd), 0);
    endtask

    task automatic t_stack();
        run(mk_va(2'b01, 21'd5, 9'h0F0), 2'd1, 1'b0);
        chk("R4 status", 64'(r_st), 0);
        chk("R4 first read", 64'(rd_log[rd_base % 64]), 64'h10C);
        chk("R4 second read", 64'(rd_log[(rd_base + 1) % 64]), 64'h414);
        chk("R4 paddr", 64'(r_pa), 64'({21'h1F00F, 9'h0F0}));
        run(mk_va(2'b01, 21'd4, 9'h001), 2'd1, 1'b0);
        chk("R4 boundary page ok", 64'(r_pa), 64'({21'h00044, 9'h001}));
        run(mk_va(2'b01, 21'd3, 9'h0), 2'd1, 1'b0);
        chk("R4 below limit", 64'(r_st), 2);
        chk("R4 no access", 64'(r_nrd), 0);
    endtask

    task automatic t_table_region();
        prg_base = 32'h0000_0410;
        run(mk_va(2'b00, 21'd0, 9'h0), 2'd0, 1'b0);
        chk("R5 table outside system", 64'(r_st), 6);
        chk("R5 no access", 64'(r_nrd), 0);
        prg_base = 32'h8000_2000;
        run(mk_va(2'b00, 21'd0, 9'h0), 2'd0, 1'b0);
        chk("R5 table page length", 64'(r_st), 2);
        chk("R5 no access on length", 64'(r_nrd), 0);
        prg_base = 32'h8000_0410;
    endtask

    task automatic t_faults();
        run(mk_va(2'b00, 21'd1, 9'h0), 2'd0, 1'b0);
        chk("R7 leaf fault user", 64'(r_st), 4);
        run(mk_va(2'b10, 21'd6, 9'h0), 2'd0, 1'b0);
        chk("R7 leaf fault system", 64'(r_st), 4);
        mem[66] = mk_pte(1'b0, 4'hF, 1'b0, 21'd1);
        run(mk_va(2'b00, 21'd0, 9'h0), 2'd0, 1'b0);
        chk("R7 table page fault", 64'(r_st), 3);
        chk("R7 one read only", 64'(r_nrd), 1);
        mem[66] = mk_pte(1'b1, 4'hF, 1'b0, 21'd1);
    endtask

    task automatic t_protect();
        run(mk_va(2'b10, 21'd5, 9'h002), 2'd0, 1'b1);
        chk("R8 write allowed", 64'(r_st), 0);
        chk("R9 one write", 64'(r_nwr), 1);
        chk("R9 write address", 64'(wr_addr_last), 64'h114);
        chk("R9 write data", 64'(wr_data_last), 64'(mk_pte(1'b1, 4'b0011, 1'b1, 21'h12345)));
        run(mk_va(2'b10, 21'd5, 9'h002), 2'd1, 1'b1);
        chk("R8 write denied", 64'(r_st), 5);
        chk("R8 no write back", 64'(r_nwr), 0);
        run(mk_va(2'b00, 21'd2, 9'h0), 2'd3, 1'b0);
        chk("R8 read denied", 64'(r_st), 5);
        run(mk_va(2'b00, 21'd2, 9'h0), 2'd2, 1'b0);
        chk("R8 read at limit", 64'(r_st), 0);
        chk("R9 read no write", 64'(r_nwr), 0);
        run(mk_va(2'b00, 21'd2, 9'h011), 2'd1, 1'b1);
        chk("R9 user write ok", 64'(r_pa), 64'({21'h00100, 9'h011}));
        chk("R9 user write address", 64'(wr_addr_last), 64'h218);
    endtask

    task automatic t_handshake();
        issue(mk_va(2'b00, 21'd0, 9'h1C0), 2'd0, 1'b0);
        @(negedge clk);
        vaddr = mk_va(2'b11, 21'd0, 9'h0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk("R10 busy start ignored", 64'(r_st), 0);
        chk("R10 own result", 64'(r_pa), 64'({21'h00077, 9'h1C0}));
        chk("R10 two reads", 64'(r_nrd), 2);
        // start in the cycle done is seen
        vaddr = mk_va(2'b11, 21'd3, 9'h0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 start taken with done", 64'(done), 1);
        chk("R10 second status", 64'(status), 1);
        @(negedge clk);
        chk("R10 done pulse ends", 64'(done), 0);
    endtask

    initial begin
        bit wd_hit = 1'b0;
        rst_n    = 1'b0;
        start    = 1'b0;
        vaddr    = '0;
        mode     = '0;
        write    = 1'b0;
        sys_base = 30'h100;
        sys_len  = 22'd8;
        prg_base = 32'h8000_0410;
        prg_len  = 22'd4;
        stk_base = 32'h8000_0600;
        stk_len  = 22'd4;
        for (int i = 0; i < 512; i++) mem[i] = '0;
        mem[66]  = mk_pte(1'b1, 4'hF, 1'b0, 21'd1);       // system page 2
        mem[67]  = mk_pte(1'b1, 4'hF, 1'b0, 21'd2);       // system page 3
        mem[69]  = mk_pte(1'b1, 4'b0011, 1'b0, 21'h12345);
        mem[70]  = mk_pte(1'b0, 4'hF, 1'b0, 21'h00001);
        mem[71]  = mk_pte(1'b1, 4'hF, 1'b0, 21'h00ABC);
        mem[132] = mk_pte(1'b1, 4'hF, 1'b0, 21'h00077);   // program page 0
        mem[133] = mk_pte(1'b0, 4'hF, 1'b0, 21'h00010);
        mem[134] = mk_pte(1'b1, 4'b0110, 1'b0, 21'h00100);
        mem[260] = mk_pte(1'b1, 4'hF, 1'b0, 21'h00044);   // stack page 4
        mem[261] = mk_pte(1'b1, 4'hF, 1'b0, 21'h1F00F);
        repeat (3) @(negedge clk);
        fork
            begin
                t_reset();
                rst_n = 1'b1;
                t_system();
                t_bad_region();
                t_program();
                t_stack();
                t_table_region();
                t_faults();
                t_protect();
                t_handshake();
            end
            begin
                repeat (150000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule